// File: doc/BRIEF.md
# Programmable PWM Wave Generator

This block produces a single pulse-width-modulated output from a free-running clock. A short write port loads four configuration words: a control word with the run bit and the slope mode, a 15-bit counter ceiling, a 3-bit power-of-two clock divider and a duty value. The divided clock advances a period counter. In sawtooth mode the counter climbs to the ceiling and wraps, which gives edge-aligned pulses. In triangle mode it climbs and then descends, which gives pulses centred on count zero.

The duty value is double-buffered. A write lands in a staging register, and the live compare register takes it only when a period closes, so a pulse is never cut short or stretched mid-period. A one-clock strobe marks each period boundary so that a host can time its next duty update.

Top module: `pwm_wave_gen`

## Requirements
- R1: After reset the run bit is 0. While it is 0, `pwm_out` and `period_end` stay low and the counter is held at 0.
- R2: The divider field n (bits 2:0 of word 2, reset 0) advances the counter once every 2^n clocks, for n = 0..7.
- R3: With mode bit (word 0, bit 1) = 0 the counter runs 0,1,..,top and then back to 0, so a period lasts (top+1)·2^n clocks.
- R4: With mode bit = 1 the counter runs 0 up to top and back down to 0, so a period lasts 2·top·2^n clocks.
- R5: The ceiling (word 1, bits 14:0) resets to 1023, and any written value below 3 is stored as 3.
- R6: A duty write (word 3, bits 14:0) reaches the compare register only when the counter returns to 0, or at once while the run bit is 0.
- R7: `pwm_out` is high one clock after a counter value below the compare value, on both slopes.
- R8: A compare value of 0 gives a constant low output. A compare value at or above the ceiling gives a constant high output.
- R9: `period_end` is high for exactly one clock, in the clock in which the counter has just returned to 0.
- R10: Clearing the run bit clears the divider and the counter. With top T and n = 0, the first `period_end` after the run bit is set comes T+1 clocks after the write edge.
- R11: Word addresses are 0 for control (bit 0 run, bit 1 mode), 1 for the ceiling, 2 for the divider and 3 for the duty value. A write takes effect at the clock edge on which `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration word select |
| wr_data | input | 16 | Configuration write data |
| pwm_out | output | 1 | Registered PWM output |
| period_end | output | 1 | One-clock strobe at each period boundary |

## Verification
A configuration write changes the internal registers at its own edge. The counter first reacts at the next edge. `period_end` rises together with the counter's return to zero. `pwm_out` follows the counter one edge later. A write therefore shows at the pins two edges after it is sampled, and a duty write shows only after the next boundary. The bench's model advances on the same edges from the same inputs, and both outputs are compared at every falling edge. The measured period lengths and high-time counts are taken between consecutive `period_end` strobes, so they do not depend on where a window starts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TOP  = 2'd1,
    REG_DIV  = 2'd2,
    REG_DUTY = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_MODE_BIT = 1;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int DIV_W   = 3,
  parameter int DATA_W  = 16,
  parameter int TOP_RST = 1023,
  parameter int TOP_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run,
  output logic              center,
  output logic [CNT_W-1:0]  top,
  output logic [DIV_W-1:0]  div,
  output logic [CNT_W-1:0]  duty_stage
);
  localparam logic [CNT_W-1:0] TOP_RST_V = CNT_W'(TOP_RST);
  localparam logic [CNT_W-1:0] TOP_MIN_V = CNT_W'(TOP_MIN);

  logic [CNT_W-1:0] top_in;
  assign top_in = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      center     <= 1'b0;
      top        <= TOP_RST_V;
      div        <= '0;
      duty_stage <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        REG_CTRL: begin
          run    <= wr_data[CTRL_RUN_BIT];
          center <= wr_data[CTRL_MODE_BIT];
        end
        REG_TOP:  top        <= (top_in < TOP_MIN_V) ? TOP_MIN_V : top_in;
        REG_DIV:  div        <= wr_data[DIV_W-1:0];
        REG_DUTY: duty_stage <= wr_data[CNT_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  assign mask = {PRE_W{1'b1}} >> (PRE_W - int'(div));
  assign tick = run && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run)  pre_cnt <= '0;
    else if (tick)    pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_wave_counter.sv
module pwm_wave_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary
);
  logic falling;
  logic at_top;
  logic at_floor;

  assign at_top   = (cnt >= top);
  assign at_floor = (cnt <= CNT_W'(1));
  assign boundary = tick && (center ? (falling && at_floor) : at_top);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      falling <= 1'b0;
    end else if (tick) begin
      if (!center) begin
        falling <= 1'b0;
        cnt     <= at_top ? '0 : cnt + 1'b1;
      end else if (!falling) begin
        if (at_top) begin
          falling <= 1'b1;
          cnt     <= cnt - 1'b1;
        end else begin
          cnt     <= cnt + 1'b1;
        end
      end else if (at_floor) begin
        falling <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt     <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int DIV_W   = 3,
  parameter int DATA_W  = 16,
  parameter int TOP_RST = 1023,
  parameter int TOP_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              period_end
);
  logic             en_q;
  logic             center_q;
  logic [CNT_W-1:0] top_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] duty_stage;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             boundary;
  logic             out_next;

  pwm_cfg_regs #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W),
    .TOP_RST(TOP_RST), .TOP_MIN(TOP_MIN)
  ) i_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(en_q), .center(center_q), .top(top_q), .div(div_q),
    .duty_stage(duty_stage)
  );

  pwm_prescaler #(.DIV_W(DIV_W)) i_pre (
    .clk(clk), .rst(rst), .run(en_q), .div(div_q), .tick(tick)
  );

  pwm_wave_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .run(en_q), .tick(tick), .center(center_q),
    .top(top_q), .cnt(cnt), .boundary(boundary)
  );

  assign out_next = en_q && ((cmp_act >= top_q) || (cnt < cmp_act));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_act    <= '0;
      pwm_out    <= 1'b0;
      period_end <= 1'b0;
    end else begin
      if (!en_q || boundary) cmp_act <= duty_stage;
      pwm_out    <= out_next;
      period_end <= boundary;
    end
  end
endmodule

// File: rtl/pwm_wave_gen_chk.sv
module pwm_wave_gen_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic             center_q,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_q,
  input logic [CNT_W-1:0] cmp_act,
  input logic             pwm_out,
  input logic             period_end
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (!pwm_out && !period_end));

  // R9
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    period_end |-> (cnt == '0));

  // R6
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !period_end) |-> $stable(cmp_act));

  // R2
  count_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !$past(tick)) |-> $stable(cnt));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && $past(tick) && !$past(center_q) && ($past(cnt) < $past(top_q)))
      |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R8
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && cmp_act == '0) |=> !pwm_out);
endmodule

bind pwm_wave_gen pwm_wave_gen_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .center_q(center_q), .tick(tick),
  .cnt(cnt), .top_q(top_q), .cmp_act(cmp_act), .pwm_out(pwm_out),
  .period_end(period_end)
);

// File: tb/test_pwm_wave_gen.sv
module test_pwm_wave_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;
  logic        period_end;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  string phase = "R1";

  pwm_wave_gen i_pwm_wave_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .period_end(period_end)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int m_en, m_mode, m_top, m_div, m_stage, m_act, m_pre, m_cnt, m_down, m_out, m_pe;

  always @(posedge clk) begin
    int mask, n_cnt, n_down, n_pre, n_act, bnd, tk;
    if (rst) begin
      m_en = 0; m_mode = 0; m_top = 1023; m_div = 0; m_stage = 0; m_act = 0;
      m_pre = 0; m_cnt = 0; m_down = 0; m_out = 0; m_pe = 0;
    end else begin
      mask = (1 << m_div) - 1;
      tk = m_en && ((m_pre & mask) == mask);
      m_out = m_en && (m_act >= m_top || m_cnt < m_act);
      bnd = 0; n_cnt = m_cnt; n_down = m_down; n_act = m_act;
      if (!m_en) begin
        n_pre = 0; n_cnt = 0; n_down = 0; n_act = m_stage;
      end else begin
        n_pre = tk ? 0 : m_pre + 1;
        if (tk) begin
          if (m_mode == 0) begin
            n_down = 0;
            if (m_cnt >= m_top) begin n_cnt = 0; bnd = 1; end
            else n_cnt = m_cnt + 1;
          end else if (m_down == 0) begin
            if (m_cnt >= m_top) begin n_down = 1; n_cnt = m_cnt - 1; end
            else n_cnt = m_cnt + 1;
          end else if (m_cnt <= 1) begin
            n_cnt = 0; n_down = 0; bnd = 1;
          end else n_cnt = m_cnt - 1;
        end
        if (bnd) n_act = m_stage;
      end
      m_pre = n_pre; m_cnt = n_cnt; m_down = n_down; m_act = n_act; m_pe = bnd;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_en = wr_data[0]; m_mode = wr_data[1]; end
          2'd1: m_top = (wr_data[14:0] < 3) ? 3 : int'(wr_data[14:0]);
          2'd2: m_div = int'(wr_data[2:0]);
          default: m_stage = int'(wr_data[14:0]);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (pwm_out !== m_out[0] || period_end !== m_pe[0]) begin
        miscompares++;
        $display("FAIL %s: pwm_out=%0b period_end=%0b expected %0b %0b at %0t",
                 phase, pwm_out, period_end, m_out[0], m_pe[0], $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // settles over two boundaries, then measures one full period
  task automatic measure(output int cycles, output int highs);
    int pulse;
    for (int k = 0; k < 2; k++) begin
      do @(negedge clk); while (!period_end);
    end
    cycles = 0; highs = 0; pulse = 0;
    do begin
      @(negedge clk);
      cycles++;
      highs += pwm_out;
    end while (!period_end);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int cyc, hi, wait_n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset pwm_out", pwm_out, 0);
    check("R1 reset period_end", period_end, 0);

    phase = "R1";
    wr(2'd3, 16'd5);
    repeat (40) @(negedge clk);
    check("R1 idle pwm_out", pwm_out, 0);

    phase = "R11";
    wr(2'd1, 16'd9);
    wr(2'd3, 16'd4);
    wr(2'd0, 16'h0001);
    phase = "R3";
    measure(cyc, hi);
    check("R3 up period top=9", cyc, 10);
    check("R7 up high count duty=4", hi, 4);

    phase = "R2";
    wr(2'd2, 16'd2);
    measure(cyc, hi);
    check("R2 period div=4", cyc, 40);
    check("R7 high count div=4", hi, 16);
    wr(2'd2, 16'd0);

    phase = "R4";
    wr(2'd1, 16'd8);
    wr(2'd3, 16'd3);
    wr(2'd0, 16'h0003);
    measure(cyc, hi);
    check("R4 center period top=8", cyc, 16);
    check("R7 center high count duty=3", hi, 5);

    phase = "R6";
    wr(2'd3, 16'd6);
    repeat (5) @(negedge clk);
    wr(2'd3, 16'd1);
    measure(cyc, hi);
    check("R6 center high count duty=1", hi, 1);

    phase = "R5";
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd1);
    wr(2'd3, 16'd2);
    measure(cyc, hi);
    check("R5 clamped period", cyc, 4);
    check("R5 clamped high count", hi, 2);

    phase = "R8";
    wr(2'd1, 16'd9);
    wr(2'd3, 16'd0);
    measure(cyc, hi);
    check("R8 duty=0 high count", hi, 0);
    wr(2'd3, 16'd9);
    measure(cyc, hi);
    check("R8 duty=top high count", hi, 10);
    wr(2'd3, 16'd200);
    measure(cyc, hi);
    check("R8 duty>top high count", hi, 10);

    phase = "R10";
    wr(2'd3, 16'd4);
    repeat (3) @(negedge clk);
    wr(2'd0, 16'h0000);
    repeat (7) @(negedge clk);
    check("R10 disabled pwm_out", pwm_out, 0);
    wr(2'd0, 16'h0001);
    wait_n = 1;
    while (!period_end && wait_n < 100) begin
      @(negedge clk);
      if (!period_end) wait_n++;
    end
    check("R10 first boundary delay", wait_n, 10);
    phase = "R9";
    @(negedge clk);
    check("R9 strobe one clock", period_end, 0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule